// File: doc/BRIEF.md
# Sixteen-Bit Arithmetic, Logic and Shift Unit

This block is a purely combinational datapath element. It takes two 16-bit operands and a five-bit function code made of four select bits and a carry-in. It returns a 16-bit result and four status flags: overflow, sign, zero and carry. Inside are four units that all work on the operands at the same time: an adder, a bitwise logic unit, a right shifter and a left shifter. The upper two select bits steer a four-way multiplexer that picks one of them. The lower two select bits choose the operation inside the chosen unit.

A separate carry-flag input feeds the two rotates that pass through carry. The surrounding processor normally drives it from its stored carry status. There is no clock and no state, so results follow the inputs in the same cycle.

Top module: `alsu16`

## Requirements
- R1: funcSel[3:2] picks the unit whose output reaches `result` and the flags: 00 arithmetic, 01 logic, 10 right shift, 11 left shift. funcSel[1:0] picks the operation inside the unit.
- R2: With carryIn=0, the arithmetic unit yields A, A+B, A-B-1 and A-1 (modulo 2^16) for funcSel[1:0] = 00, 01, 10, 11.
- R3: With carryIn=1, the arithmetic unit yields A+1, A+B+1, A-B and A (modulo 2^16) for the same codes.
- R4: For arithmetic, the adder forms A + Y + carryIn, where Y is 0, B, NOT B or all ones for codes 00..11. `carryOut` is bit 16 of that sum. `ovfFlag` is 1 when the signed sum of A, Y and carryIn lies outside -32768..32767.
- R5: The logic unit yields A AND B, A OR B, A XOR B and NOT A for codes 00..11, with `carryOut` and `ovfFlag` both 0.
- R6: The right unit shifts A right by one bit. The new bit 15 is 0 for code 00, A[0] for code 01 and A[15] for code 11. `carryOut` is A[0` and `ovfFlag` is 0.
- R7: For code 10, the right unit places `carryFlag` into bit 15 and the left unit places it into bit 0. No other function depends on `carryFlag`.
- R8: The left unit shifts A left by one bit. The new bit 0 is 0 for codes 00 and 11, and A[15] for code 01. `carryOut` is A[15]. `ovfFlag` is A[15] XOR A[14] for code 11 and 0 for the other codes.
- R9: `zeroFlag` is 1 exactly when all 16 result bits are 0.
- R10: `signFlag` equals result bit 15.
- R11: The block holds no state. Every output is a function of the present inputs alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| funcSel | input | 4 | Unit select [3:2] and operation select [1:0] |
| carryIn | input | 1 | Carry-in bit of the function code |
| carryFlag | input | 1 | Stored carry used by the through-carry rotates |
| result | output | 16 | Selected unit output |
| ovfFlag | output | 1 | Overflow status |
| signFlag | output | 1 | Sign status |
| zeroFlag | output | 1 | Zero status |
| carryOut | output | 1 | Carry status |

## Verification
Every output is due in the same cycle as its stimulus, because no register lies between inputs and outputs. The bench drives new operands and function codes just after each rising edge. It compares result, carry/overflow, zero and sign against its behavioural model at the following falling edge, half a cycle later. By then the combinational paths have settled, and no compare coincides with an input change. Directed vectors sweep all thirty-two function codes with both carry-flag values and the signed-overflow and zero corners. A random phase then exercises R11 with fresh inputs on every cycle.

// File: rtl/alsu_pkg.sv
package alsu_pkg;
  typedef enum logic [1:0] {
    UNIT_ARITH = 2'b00,
    UNIT_LOGIC = 2'b01,
    UNIT_SHR   = 2'b10,
    UNIT_SHL   = 2'b11
  } unitSel_e;

  typedef struct packed {
    logic       arithEn;
    logic       logicEn;
    logic       shrEn;
    logic       shlEn;
    logic [1:0] opSel;
    logic       cin;
  } ctrlStrobes_t;
endpackage

// File: rtl/alsu_ctrl.sv
module alsu_ctrl
  import alsu_pkg::*;
(
  input  logic [3:0]   funcSel,
  input  logic         carryIn,
  output ctrlStrobes_t strobes
);
  unitSel_e unitSel;

  always_comb begin
    unitSel         = unitSel_e'(funcSel[3:2]);
    strobes         = '0;
    strobes.opSel   = funcSel[1:0];
    strobes.cin     = carryIn;
    case (unitSel)
      UNIT_ARITH: strobes.arithEn = 1'b1;
      UNIT_LOGIC: strobes.logicEn = 1'b1;
      UNIT_SHR:   strobes.shrEn   = 1'b1;
      default:    strobes.shlEn   = 1'b1;
    endcase
  end

  // R1
  always_comb begin
    unit_onehot_chk: assert ($onehot({strobes.arithEn, strobes.logicEn, strobes.shrEn, strobes.shlEn}));
  end
endmodule

// File: rtl/alsu_dp.sv
module alsu_dp
  import alsu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryFlag,
  input  ctrlStrobes_t     strobes,
  output logic [WIDTH-1:0] result,
  output logic             ovfFlag,
  output logic             signFlag,
  output logic             zeroFlag,
  output logic             carryOut
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] addend, arithRes, logicRes, shrRes, shlRes;
  logic [WIDTH:0]   sumWide;
  logic             arithC, arithV, shrFill, shlFill, shlV;

  // arithmetic unit: A + Y + cin
  always_comb begin
    case (strobes.opSel)
      2'b00:   addend = '0;
      2'b01:   addend = opB;
      2'b10:   addend = ~opB;
      default: addend = '1;
    endcase
    sumWide  = {1'b0, opA} + {1'b0, addend} + {{WIDTH{1'b0}}, strobes.cin};
    arithRes = sumWide[MSB:0];
    arithC   = sumWide[WIDTH];
    arithV   = (opA[MSB] == addend[MSB]) && (arithRes[MSB] != opA[MSB]);
  end

  // logic unit
  always_comb begin
    case (strobes.opSel)
      2'b00:   logicRes = opA & opB;
      2'b01:   logicRes = opA | opB;
      2'b10:   logicRes = opA ^ opB;
      default: logicRes = ~opA;
    endcase
  end

  // right shift unit
  always_comb begin
    case (strobes.opSel)
      2'b00:   shrFill = 1'b0;
      2'b01:   shrFill = opA[0];
      2'b10:   shrFill = carryFlag;
      default: shrFill = opA[MSB];
    endcase
    shrRes = {shrFill, opA[MSB:1]};
  end

  // left shift unit
  always_comb begin
    case (strobes.opSel)
      2'b01:   shlFill = opA[MSB];
      2'b10:   shlFill = carryFlag;
      default: shlFill = 1'b0;
    endcase
    shlRes = {opA[MSB-1:0], shlFill};
    shlV   = (strobes.opSel == 2'b11) && (opA[MSB] ^ opA[MSB-1]);
  end

  // output multiplexer and flags
  always_comb begin
    if (strobes.arithEn) begin
      result = arithRes; carryOut = arithC; ovfFlag = arithV;
    end else if (strobes.logicEn) begin
      result = logicRes; carryOut = 1'b0; ovfFlag = 1'b0;
    end else if (strobes.shrEn) begin
      result = shrRes; carryOut = opA[0]; ovfFlag = 1'b0;
    end else begin
      result = shlRes; carryOut = opA[MSB]; ovfFlag = shlV;
    end
    zeroFlag = ~|result;
    signFlag = result[MSB];
  end

  always_comb begin
    // R5
    logic_flags_chk: assert (!strobes.logicEn || (!carryOut && !ovfFlag));
    // R6
    shr_carry_chk: assert (!strobes.shrEn || (carryOut == opA[0] && !ovfFlag));
    // R8
    shl_carry_chk: assert (!strobes.shlEn || carryOut == opA[MSB]);
    // R7
    rotc_fill_chk: assert (!(strobes.shrEn && strobes.opSel == 2'b10) || result[MSB] == carryFlag);
    // R3
    arith_pass_chk: assert (!(strobes.arithEn && strobes.cin && strobes.opSel == 2'b11) || result == opA);
  end
endmodule

// File: rtl/alsu16.sv
module alsu16
  import alsu_pkg::*;
(
  input  logic [15:0] opA,
  input  logic [15:0] opB,
  input  logic [3:0]  funcSel,
  input  logic        carryIn,
  input  logic        carryFlag,
  output logic [15:0] result,
  output logic        ovfFlag,
  output logic        signFlag,
  output logic        zeroFlag,
  output logic        carryOut
);
  ctrlStrobes_t strobes;

  alsu_ctrl uCtrl (
    .funcSel (funcSel),
    .carryIn (carryIn),
    .strobes (strobes)
  );

  alsu_dp #(.WIDTH(16)) uDp (
    .opA       (opA),
    .opB       (opB),
    .carryFlag (carryFlag),
    .strobes   (strobes),
    .result    (result),
    .ovfFlag   (ovfFlag),
    .signFlag  (signFlag),
    .zeroFlag  (zeroFlag),
    .carryOut  (carryOut)
  );
endmodule

// File: tb/sim_alsu16.sv
`timescale 1ns/1ps
module sim_alsu16;
  logic        clk = 1'b0;
  logic [15:0] opA = '0, opB = '0;
  logic [3:0]  funcSel = '0;
  logic        carryIn = 1'b0, carryFlag = 1'b0;
  logic [15:0] result;
  logic        ovfFlag, signFlag, zeroFlag, carryOut;
  int checks = 0, failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  alsu16 u0 (.opA(opA), .opB(opB), .funcSel(funcSel), .carryIn(carryIn), .carryFlag(carryFlag),
             .result(result), .ovfFlag(ovfFlag), .signFlag(signFlag), .zeroFlag(zeroFlag), .carryOut(carryOut));

  int expRes, expC, expV, expZ, expS;

  task automatic model(input int a, input int b, input int fs, input int ci, input int cf);
    int op, y, full, sa, sy, ss, top, low;
    op = fs % 4; expV = 0; expC = 0;
    case (fs / 4)
      0: begin
        y = (op == 0) ? 0 : (op == 1) ? b : (op == 2) ? 65535 - b : 65535;
        full = a + y + ci;
        expRes = full % 65536; expC = full / 65536;
        sa = (a >= 32768) ? a - 65536 : a;
        sy = (y >= 32768) ? y - 65536 : y;
        ss = sa + sy + ci;
        expV = (ss > 32767 || ss < -32768) ? 1 : 0;
      end
      1: expRes = (op == 0) ? (a & b) : (op == 1) ? (a | b) : (op == 2) ? (a ^ b) : (65535 - a);
      2: begin
        top = (op == 0) ? 0 : (op == 1) ? a % 2 : (op == 2) ? cf : a / 32768;
        expRes = a / 2 + top * 32768; expC = a % 2;
      end
      default: begin
        low = (op == 1) ? a / 32768 : (op == 2) ? cf : 0;
        expRes = (a * 2) % 65536 + low; expC = a / 32768;
        if (op == 3) expV = (a / 32768) ^ ((a / 16384) % 2);
      end
    endcase
    expZ = (expRes == 0) ? 1 : 0;
    expS = expRes / 32768;
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive after the rising edge, compare at the falling edge (R11: same-cycle outputs)
  task automatic runVec(input int a, input int b, input int fs, input int ci, input int cf, input string resTag);
    string rt, ft;
    int op;
    @(posedge clk); #0.5;
    opA = 16'(a); opB = 16'(b); funcSel = 4'(fs); carryIn = 1'(ci); carryFlag = 1'(cf);
    model(a, b, fs, ci, cf);
    @(negedge clk);
    op = fs % 4;
    case (fs / 4)
      0: begin rt = ci ? "R3" : "R2"; ft = "R4"; end
      1: begin rt = "R5"; ft = "R5"; end
      2: begin rt = (op == 2) ? "R7" : "R6"; ft = "R6"; end
      default: begin rt = (op == 2) ? "R7" : "R8"; ft = "R8"; end
    endcase
    if (resTag != "") rt = resTag;
    check(rt, "result", int'(result), expRes);
    check(ft, "carryOut", int'(carryOut), expC);
    check(ft, "ovfFlag", int'(ovfFlag), expV);
    check("R9", "zeroFlag", int'(zeroFlag), expZ);
    check("R10", "signFlag", int'(signFlag), expS);
  endtask

  initial begin
    // quiescent inputs: ADD-pass of zero -> result 0, Z set
    @(negedge clk);
    check("R9", "idle zeroFlag", int'(zeroFlag), 1);
    check("R2", "idle result", int'(result), 0);
    // R1: every code with the same operands, both carry-in and carry-flag values
    for (int fs = 0; fs < 16; fs++)
      for (int k = 0; k < 4; k++) runVec(16'hB5C3, 16'h6A0F, fs, k % 2, k / 2, "R1");
    // R4 corners: signed overflow, carry, borrow
    runVec(16'h7FFF, 16'h0001, 1, 0, 0, "");
    runVec(16'h8000, 16'h8000, 1, 0, 0, "");
    runVec(16'h8000, 16'h0001, 2, 1, 0, "");
    runVec(16'h0005, 16'h0005, 2, 1, 0, "");
    runVec(16'h0000, 16'h0000, 3, 0, 0, "");
    runVec(16'hFFFF, 16'h0000, 0, 1, 0, "");
    runVec(16'h8000, 16'h0000, 3, 0, 0, "");
    // R5 zero result, R6/R8 edge bits, R7 carry flag
    runVec(16'hF0F0, 16'h0F0F, 4, 0, 1, "");
    runVec(16'hFFFF, 16'h0000, 7, 0, 1, "");
    runVec(16'h0001, 16'h0000, 8, 0, 1, "");
    runVec(16'h8001, 16'h0000, 11, 0, 1, "");
    runVec(16'h0000, 16'h0000, 10, 0, 1, "");
    runVec(16'h0000, 16'h0000, 14, 0, 1, "");
    runVec(16'h4000, 16'h0000, 15, 0, 0, "");
    runVec(16'hC000, 16'h0000, 15, 0, 0, "");
    runVec(16'h8000, 16'h0000, 13, 0, 0, "");
    // R11: fresh random inputs every cycle
    for (int i = 0; i < 2000; i++)
      runVec(int'($urandom_range(65535)), int'($urandom_range(65535)), int'($urandom_range(15)),
             int'($urandom_range(1)), int'($urandom_range(1)), "R11");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule